// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit operand address description into a 20-bit physical byte address, in the way a 16-bit segmented processor does in real mode. The caller supplies an addressing-mode code, the four pointer registers (two base and two index), a displacement with a byte/word size flag, and the four segment registers. The caller may also force a segment. The block forms the 16-bit effective offset, picks the segment, and adds the segment value shifted left by four bits to the offset.

A request strobe starts each computation. The effective offset and the physical address come out registered on the next clock edge, together with a one-cycle valid pulse. Between requests the outputs hold their last values. Both adders wrap: the offset wraps modulo 65536 and the physical address wraps modulo 2^20.

Top module: `rm_addr_gen`

## Requirements
- R1: While rst_n is low at a clock edge, valid, phys_addr and eff_ofs are cleared to zero at that edge.
- R2: valid is high in exactly the cycle after a cycle with req high. After a cycle with req low, valid is low and phys_addr and eff_ofs keep their previous values.
- R3: The eff_ofs value depends on mode. Code 0 gives disp (direct). Code 1 gives one register (register indirect). Code 2 gives index+disp. Code 3 gives base+disp. Code 4 gives base+index. Code 5 gives base+index+disp.
- R4: When disp_byte is 1, only disp[7:0] is used, sign-extended to 16 bits. When disp_byte is 0, all 16 bits of disp are used.
- R5: base_sel selects the base register (0 = BX, 1 = BP). idx_sel selects the index register (0 = SI, 1 = DI). In mode 1, ind_base=1 uses the selected base register and ind_base=0 uses the selected index register.
- R6: With ovr_en low, the segment is SS when the offset includes BP. That is the case in modes 3, 4 and 5 with base_sel=1, and in mode 1 with ind_base=1 and base_sel=1. In every other case the segment is DS.
- R7: With ovr_en high, ovr_sel picks the segment: 0 = ES, 1 = CS, 2 = SS, 3 = DS. This holds whatever the mode is.
- R8: phys_addr = (segment * 16 + eff_ofs) mod 2^20. For example, segment 3813h spans 38130h to 4812Fh.
- R9: The offset sum wraps modulo 65536 before the segment is added.
- R10: Mode codes 6 and 7 behave as direct mode (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Compute request strobe |
| mode | input | 3 | Addressing-mode code |
| base_sel | input | 1 | Base register pick: 0 BX, 1 BP |
| idx_sel | input | 1 | Index register pick: 0 SI, 1 DI |
| ind_base | input | 1 | Register-indirect source: 1 base, 0 index |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| disp | input | 16 | Displacement |
| disp_byte | input | 1 | 1: displacement is the signed low byte |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment code |
| valid | output | 1 | Result valid pulse |
| phys_addr | output | 20 | Registered physical address |
| eff_ofs | output | 16 | Registered effective offset |

## Verification
The assertions assume that req, mode and the register and segment inputs are stable and defined at the clock edge where req is sampled. They also assume that req is held low throughout reset, because the properties look one cycle back. The bench changes inputs only 1 ns after a rising edge and keeps req low during reset. It drives every mode code, every override code and both displacement sizes, and adds values that make both adders wrap.

// File: rtl/rm_agu_pkg.sv
// Package: shared encodings for the real-mode address generator.
// Assumes a 3-bit mode code and a 2-bit segment code.
package rm_agu_pkg;
    typedef enum logic [2:0] {
        AM_DIRECT    = 3'd0,
        AM_REGIND    = 3'd1,
        AM_INDEXED   = 3'd2,
        AM_BASED     = 3'd3,
        AM_BIDX      = 3'd4,
        AM_BIDX_DISP = 3'd5
    } am_mode_e;

    typedef enum logic [1:0] {
        SG_ES = 2'd0,
        SG_CS = 2'd1,
        SG_SS = 2'd2,
        SG_DS = 2'd3
    } seg_id_e;
endpackage

// File: rtl/agu_offset.sv
// Module: forms the wrapped effective offset from the mode code, the pointer
// registers and the displacement. It also flags offsets built on BP.
// Assumes: codes 6 and 7 are treated as direct mode.
module agu_offset
    import rm_agu_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [2:0]       mode,
    input  logic             base_sel,
    input  logic             idx_sel,
    input  logic             ind_base,
    input  logic [OFS_W-1:0] reg_bx,
    input  logic [OFS_W-1:0] reg_bp,
    input  logic [OFS_W-1:0] reg_si,
    input  logic [OFS_W-1:0] reg_di,
    input  logic [OFS_W-1:0] disp,
    input  logic             disp_byte,
    output logic [OFS_W-1:0] ofs,
    output logic             bp_based
);
    localparam int EXT_W = OFS_W - BYTE_W;

    logic [OFS_W-1:0] disp_ext;
    logic [OFS_W-1:0] base_v;
    logic [OFS_W-1:0] idx_v;
    am_mode_e         m;

    // Purpose: sign-extend a byte displacement or pass a word displacement through.
    always_comb begin
        if (disp_byte)
            disp_ext = {{EXT_W{disp[BYTE_W-1]}}, disp[BYTE_W-1:0]};
        else
            disp_ext = disp;
    end

    // Purpose: pick the base register and the index register.
    always_comb begin
        base_v = base_sel ? reg_bp : reg_bx;
        idx_v  = idx_sel  ? reg_di : reg_si;
    end

    // Purpose: sum the terms of the selected mode; the sum wraps at OFS_W bits.
    always_comb begin
        m        = am_mode_e'(mode);
        ofs      = disp_ext;
        bp_based = 1'b0;
        case (m)
            AM_DIRECT: ofs = disp_ext;
            AM_REGIND: begin
                ofs      = ind_base ? base_v : idx_v;
                bp_based = ind_base & base_sel;
            end
            AM_INDEXED: ofs = idx_v + disp_ext;
            AM_BASED: begin
                ofs      = base_v + disp_ext;
                bp_based = base_sel;
            end
            AM_BIDX: begin
                ofs      = base_v + idx_v;
                bp_based = base_sel;
            end
            AM_BIDX_DISP: begin
                ofs      = base_v + idx_v + disp_ext;
                bp_based = base_sel;
            end
            default: ofs = disp_ext;
        endcase
    end
endmodule

// File: rtl/agu_segsel.sv
// Module: chooses the segment value. An enabled override wins; otherwise
// BP-based offsets use SS and every other offset uses DS.
// Assumes the override code order ES, CS, SS, DS.
module agu_segsel
    import rm_agu_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic             bp_based,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_sel,
    input  logic [SEG_W-1:0] seg_es,
    input  logic [SEG_W-1:0] seg_cs,
    input  logic [SEG_W-1:0] seg_ss,
    input  logic [SEG_W-1:0] seg_ds,
    output logic [SEG_W-1:0] seg
);
    seg_id_e pick;

    // Purpose: resolve which segment register applies to this access.
    always_comb begin
        if (ovr_en)
            pick = seg_id_e'(ovr_sel);
        else if (bp_based)
            pick = SG_SS;
        else
            pick = SG_DS;
    end

    // Purpose: route the chosen segment value.
    always_comb begin
        case (pick)
            SG_ES:   seg = seg_es;
            SG_CS:   seg = seg_cs;
            SG_SS:   seg = seg_ss;
            default: seg = seg_ds;
        endcase
    end
endmodule

// File: rtl/agu_phys.sv
// Module: shifts the segment, adds the offset, and registers the result with
// a valid pulse. The outputs hold their values when no request is present.
// Assumes a synchronous active-low reset.
module agu_phys #(
    parameter int OFS_W = 16,
    parameter int SHIFT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic [OFS_W-1:0]       seg,
    input  logic [OFS_W-1:0]       ofs,
    output logic                   valid_q,
    output logic [OFS_W+SHIFT-1:0] phys_q,
    output logic [OFS_W-1:0]       ofs_q
);
    localparam int PA_W = OFS_W + SHIFT;

    logic [PA_W-1:0] phys_d;

    // Purpose: segment times 2^SHIFT plus the offset; the sum wraps at PA_W bits.
    always_comb begin
        phys_d = {seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ofs};
    end

    // Purpose: capture the result on a request and pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            phys_q  <= '0;
            ofs_q   <= '0;
        end else begin
            valid_q <= req;
            if (req) begin
                phys_q <= phys_d;
                ofs_q  <= ofs;
            end
        end
    end
endmodule

// File: rtl/rm_addr_gen.sv
// Module: top of the real-mode address generator. It forms the offset, picks
// the segment and produces the registered physical address one cycle after req.
// Assumes inputs are stable at the edge where req is sampled.
module rm_addr_gen #(
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic [2:0]             mode,
    input  logic                   base_sel,
    input  logic                   idx_sel,
    input  logic                   ind_base,
    input  logic [OFS_W-1:0]       reg_bx,
    input  logic [OFS_W-1:0]       reg_bp,
    input  logic [OFS_W-1:0]       reg_si,
    input  logic [OFS_W-1:0]       reg_di,
    input  logic [OFS_W-1:0]       disp,
    input  logic                   disp_byte,
    input  logic [OFS_W-1:0]       seg_es,
    input  logic [OFS_W-1:0]       seg_cs,
    input  logic [OFS_W-1:0]       seg_ss,
    input  logic [OFS_W-1:0]       seg_ds,
    input  logic                   ovr_en,
    input  logic [1:0]             ovr_sel,
    output logic                   valid,
    output logic [OFS_W+SHIFT-1:0] phys_addr,
    output logic [OFS_W-1:0]       eff_ofs
);
    logic [OFS_W-1:0] ofs_w;
    logic [OFS_W-1:0] seg_w;
    logic             bp_w;

    agu_offset #(.OFS_W(OFS_W), .BYTE_W(BYTE_W)) u_ofs (
        .mode(mode), .base_sel(base_sel), .idx_sel(idx_sel), .ind_base(ind_base),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .disp(disp), .disp_byte(disp_byte), .ofs(ofs_w), .bp_based(bp_w)
    );

    agu_segsel #(.SEG_W(OFS_W)) u_seg (
        .bp_based(bp_w), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .seg(seg_w)
    );

    agu_phys #(.OFS_W(OFS_W), .SHIFT(SHIFT)) u_phys (
        .clk(clk), .rst_n(rst_n), .req(req), .seg(seg_w), .ofs(ofs_w),
        .valid_q(valid), .phys_q(phys_addr), .ofs_q(eff_ofs)
    );
endmodule

// File: rtl/rm_addr_gen_chk.sv
// Module: property checker for rm_addr_gen, attached to it by bind.
// Assumes req is low while reset is applied.
module rm_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic [2:0]  mode,
    input logic        base_sel,
    input logic        idx_sel,
    input logic [15:0] reg_bp,
    input logic [15:0] reg_si,
    input logic [15:0] seg_es,
    input logic [15:0] seg_ss,
    input logic        ovr_en,
    input logic [1:0]  ovr_sel,
    input logic        valid,
    input logic [19:0] phys_addr,
    input logic [15:0] eff_ofs
);
    // R1: reset clears the outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!valid && phys_addr == 20'h0 && eff_ofs == 16'h0));

    // R2: valid follows req by one cycle
    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> valid);

    // R2: no valid and held data without a request
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!valid && $stable(phys_addr) && $stable(eff_ofs)));

    // R9: base-plus-index sum wraps at 16 bits (BP + SI)
    a_r9_bidx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd4 && base_sel && !idx_sel) |=>
        eff_ofs == 16'($past(reg_bp) + $past(reg_si)));

    // R7: override code 0 selects ES; R8 address formed mod 2^20
    a_r7_override_es: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ovr_en && ovr_sel == 2'd0) |=>
        phys_addr == 20'({$past(seg_es), 4'h0} + {4'h0, eff_ofs}));

    // R6: based mode on BP with no override uses SS
    a_r6_default_ss: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ovr_en && mode == 3'd3 && base_sel) |=>
        phys_addr == 20'({$past(seg_ss), 4'h0} + {4'h0, eff_ofs}));
endmodule

bind rm_addr_gen rm_addr_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .base_sel(base_sel),
    .idx_sel(idx_sel), .reg_bp(reg_bp), .reg_si(reg_si), .seg_es(seg_es),
    .seg_ss(seg_ss), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .valid(valid),
    .phys_addr(phys_addr), .eff_ofs(eff_ofs)
);

// File: tb/sim_rm_addr_gen.sv
// Bench: behavioural reference model, compared with the design after every clock.
module sim_rm_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        base_sel = 1'b0, idx_sel = 1'b0, ind_base = 1'b0;
    logic [15:0] reg_bx = 16'h0, reg_bp = 16'h0, reg_si = 16'h0, reg_di = 16'h0;
    logic [15:0] disp = 16'h0;
    logic        disp_byte = 1'b0;
    logic [15:0] seg_es = 16'h0, seg_cs = 16'h0, seg_ss = 16'h0, seg_ds = 16'h0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = 2'd0;
    logic        valid;
    logic [19:0] phys_addr;
    logic [15:0] eff_ofs;

    int checks = 0;
    int errors = 0;
    int exp_phys = 0;
    int exp_ofs = 0;
    bit exp_valid = 0;

    always #2 clk = ~clk;

    rm_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .base_sel(base_sel),
        .idx_sel(idx_sel), .ind_base(ind_base), .reg_bx(reg_bx), .reg_bp(reg_bp),
        .reg_si(reg_si), .reg_di(reg_di), .disp(disp), .disp_byte(disp_byte),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .ovr_en(ovr_en), .ovr_sel(ovr_sel), .valid(valid),
        .phys_addr(phys_addr), .eff_ofs(eff_ofs)
    );

    // Reference offset from the requirements, computed in integers.
    function automatic int ref_ofs();
        int d, b, x, o;
        if (disp_byte) d = (disp[7] ? int'(disp[7:0]) - 256 : int'(disp[7:0]));
        else d = int'(disp);
        b = base_sel ? int'(reg_bp) : int'(reg_bx);
        x = idx_sel ? int'(reg_di) : int'(reg_si);
        case (int'(mode))
            1: o = ind_base ? b : x;
            2: o = x + d;
            3: o = b + d;
            4: o = b + x;
            5: o = b + x + d;
            default: o = d;
        endcase
        return o & 32'hFFFF;
    endfunction

    function automatic int ref_seg();
        bit uses_bp;
        if (ovr_en) begin
            case (int'(ovr_sel))
                0: return int'(seg_es);
                1: return int'(seg_cs);
                2: return int'(seg_ss);
                default: return int'(seg_ds);
            endcase
        end
        uses_bp = base_sel && ((mode >= 3 && mode <= 5) || (mode == 1 && ind_base));
        return uses_bp ? int'(seg_ss) : int'(seg_ds);
    endfunction

    // Apply req for one edge, update the model, compare after the edge.
    task automatic go(input string tag, input bit r);
        req = r;
        if (r) begin
            exp_ofs  = ref_ofs();
            exp_phys = (ref_seg() * 16 + exp_ofs) % 1048576;
        end
        exp_valid = r;
        @(posedge clk);
        #1;
        req = 1'b0;
        checks++;
        if (valid !== exp_valid || int'(phys_addr) != exp_phys || int'(eff_ofs) != exp_ofs) begin
            errors++;
            $display("FAIL %s: valid=%0b phys=%05h ofs=%04h expected valid=%0b phys=%05h ofs=%04h",
                     tag, valid, phys_addr, eff_ofs, exp_valid, exp_phys[19:0], exp_ofs[15:0]);
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++; // R1 reset state
        if (valid !== 1'b0 || phys_addr !== 20'h0 || eff_ofs !== 16'h0) begin
            errors++;
            $display("FAIL R1: valid=%0b phys=%05h ofs=%04h expected 0 0 0", valid, phys_addr, eff_ofs);
        end
        rst_n = 1'b1;
        reg_bx = 16'h1200; reg_bp = 16'h3400; reg_si = 16'h0056; reg_di = 16'h0078;
        seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h3813;

        // R8: segment window edges
        mode = 3'd0; disp = 16'h0000; go("R8", 1);
        disp = 16'hFFFF; go("R8", 1);
        // R2: idle cycle holds and drops valid
        go("R2", 0);
        go("R2", 0);
        // R3: every mode
        disp = 16'h0010;
        for (int k = 0; k < 6; k++) begin
            mode = 3'(k);
            go("R3", 1);
        end
        // R5: register picks
        mode = 3'd1; ind_base = 1; base_sel = 0; go("R5", 1);
        base_sel = 1; go("R5", 1);
        ind_base = 0; idx_sel = 1; go("R5", 1);
        mode = 3'd5; base_sel = 0; idx_sel = 1; go("R5", 1);
        // R4: byte displacement sign extension, upper bits ignored
        mode = 3'd3; base_sel = 1; disp = 16'h12F0; disp_byte = 1; go("R4", 1);
        disp = 16'hAB7F; go("R4", 1);
        disp_byte = 0; disp = 16'hFFF0; go("R4", 1);
        // R6: default segment choice
        mode = 3'd3; base_sel = 0; go("R6", 1);
        mode = 3'd4; base_sel = 1; go("R6", 1);
        mode = 3'd2; go("R6", 1);
        mode = 3'd1; ind_base = 1; base_sel = 1; go("R6", 1);
        // R7: overrides
        mode = 3'd3; base_sel = 1; ovr_en = 1;
        for (int k = 0; k < 4; k++) begin
            ovr_sel = 2'(k);
            go("R7", 1);
        end
        ovr_en = 0;
        // R9: offset wrap
        mode = 3'd2; idx_sel = 0; reg_si = 16'hFFFF; disp = 16'h0002; go("R9", 1);
        mode = 3'd5; reg_bp = 16'hF000; reg_si = 16'h1000; disp_byte = 1; disp = 16'h00FF; go("R9", 1);
        disp_byte = 0;
        // R8: physical wrap past 2^20
        mode = 3'd0; seg_ds = 16'hFFFF; disp = 16'h0020; go("R8", 1);
        // R10: reserved codes act as direct
        disp = 16'h0123; mode = 3'd6; go("R10", 1);
        mode = 3'd7; go("R10", 1);
        go("R2", 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule